// File: doc/BRIEF.md
# Multicycle Instruction Sequencing Controller

This block is the control unit of a small accumulator-style processor. It waits in a decode state until a start request arrives. It then decodes a 3-bit instruction and walks through one or more execute states. In each state it drives a 3-bit datapath operation code, a register write-enable and, for the output instruction, an output strobe. When the instruction is complete it raises a one-cycle done pulse. The ALU and the register file sit outside the block.

Most instructions execute in a single cycle. Subtraction takes two cycles. The first is a negate step that forms the two's complement of one operand register. The second reuses the same add state that the plain add instruction uses. Decode is gated by start and by bit 1 of the destination field. A start level that is simply held high does not reissue the instruction: start must be seen low after an acceptance before another one is taken.

Top module: `seq_ctrl`

## Requirements
- R1: An active-low asynchronous reset forces the decode state at once, even mid-instruction: op = 000, wr_en = 0, out_stb = 0, done = 0.
- R2: The controller leaves decode only in a cycle where start = 1, dest[1] = 0 and the controller is armed. With dest[1] = 1 it stays in decode (op 000, wr_en 0) for as long as start is held.
- R3: Instruction codes select the op codes shown one cycle after acceptance. Load (000) gives 001, transfer (001) gives 010, AND (010) gives 011, OR (011) gives 100, add (100) gives 101 and shift right (110) gives 111. Output (111) gives op 000 with the strobe set.
- R4: Every execute state except negate lasts exactly one cycle and then returns to decode.
- R5: Subtract (101) shows op 110 (negate) for exactly one cycle, then op 101 (add) for one cycle, then returns to decode.
- R6: done is 1 for exactly one cycle: the first decode cycle after the final execute state. It is 0 at every other time, including after the negate step.
- R7: wr_en is 1 in every execute state, including negate, except output. It is 0 in decode.
- R8: out_stb is 1 only in the output state. There op is 000 and wr_en is 0.
- R9: After an acceptance the controller takes no further instruction until start has been sampled 0 at least once. A start held high yields a single execution. A low start seen during execution re-arms the controller.
- R10: dest[0] has no effect on decoding or sequencing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Asynchronous reset, active low |
| start | input | 1 | Request to execute the presented instruction |
| instr | input | 3 | Instruction code |
| dest | input | 2 | Destination field; bit 1 high blocks decode |
| op | output | 3 | Datapath operation code, from current state only |
| wr_en | output | 1 | Register write-enable for the datapath |
| out_stb | output | 1 | Output-instruction strobe |
| done | output | 1 | One-cycle completion pulse |

## Verification
The hardest situation to reach is re-arming. The start line must be held high across a done pulse, or dropped during an execute state and raised again exactly when the controller returns to decode. The stimulus holds start high for many cycles and counts how many write cycles follow. It then issues a subtract, drops start during the negate step and raises it again during the add step, so that the next instruction is taken in the very cycle done is high. A reset pulled low during the negate step checks that no half-finished subtract survives.

// File: rtl/seq_ctrl.sv
module seq_ctrl (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  input  logic [2:0] instr,
  input  logic [1:0] dest,
  output logic [2:0] op,
  output logic       wr_en,
  output logic       out_stb,
  output logic       done
);

  typedef enum logic [3:0] {
    S_DEC, S_LD, S_XF, S_AND, S_OR, S_ADD, S_NEG, S_SHR, S_OUT
  } state_t;

  localparam logic [2:0] OP_IDLE = 3'b000;
  localparam logic [2:0] OP_LD   = 3'b001;
  localparam logic [2:0] OP_XF   = 3'b010;
  localparam logic [2:0] OP_AND  = 3'b011;
  localparam logic [2:0] OP_OR   = 3'b100;
  localparam logic [2:0] OP_ADD  = 3'b101;
  localparam logic [2:0] OP_NEG  = 3'b110;
  localparam logic [2:0] OP_SHR  = 3'b111;

  state_t st, st_nx;
  logic   armed, armed_nx, done_nx, go;

  assign go = (st == S_DEC) && start && !dest[1] && armed;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st    <= S_DEC;
      done  <= 1'b0;
      armed <= 1'b1;
    end else begin
      st    <= st_nx;
      done  <= done_nx;
      armed <= armed_nx;
    end
  end

  always_comb begin
    st_nx    = st;
    done_nx  = 1'b0;
    armed_nx = start ? armed : 1'b1;
    case (st)
      S_DEC: begin
        if (go) begin
          armed_nx = 1'b0;
          case (instr)
            3'b000:  st_nx = S_LD;
            3'b001:  st_nx = S_XF;
            3'b010:  st_nx = S_AND;
            3'b011:  st_nx = S_OR;
            3'b100:  st_nx = S_ADD;
            3'b101:  st_nx = S_NEG;
            3'b110:  st_nx = S_SHR;
            default: st_nx = S_OUT;
          endcase
        end
      end
      S_NEG: st_nx = S_ADD;
      default: begin
        st_nx   = S_DEC;
        done_nx = 1'b1;
      end
    endcase
  end

  always_comb begin
    op      = OP_IDLE;
    wr_en   = 1'b1;
    out_stb = 1'b0;
    case (st)
      S_DEC:   wr_en = 1'b0;
      S_LD:    op = OP_LD;
      S_XF:    op = OP_XF;
      S_AND:   op = OP_AND;
      S_OR:    op = OP_OR;
      S_ADD:   op = OP_ADD;
      S_NEG:   op = OP_NEG;
      S_SHR:   op = OP_SHR;
      S_OUT: begin
        wr_en   = 1'b0;
        out_stb = 1'b1;
      end
      default: wr_en = 1'b0;
    endcase
  end

endmodule

// File: rtl/seq_ctrl_chk.sv
module seq_ctrl_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       start,
  input logic [1:0] dest,
  input logic [2:0] op,
  input logic       wr_en,
  input logic       out_stb,
  input logic       done
);

  p_neg_then_add_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (op == 3'b110) |=> (op == 3'b101 && wr_en && !done));

  p_done_single_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_done_follows_exec_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> (op == 3'b000 && !out_stb && !wr_en));

  p_one_cycle_exec_r4: assert property (@(posedge clk) disable iff (!rst_n)
    ((wr_en && op != 3'b110) || out_stb) |=> (done && op == 3'b000 && !out_stb && !wr_en));

  p_blocked_decode_r2: assert property (@(posedge clk) disable iff (!rst_n)
    (!wr_en && !out_stb && dest[1]) |=> (!wr_en && !out_stb));

  p_strobe_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    out_stb |-> (op == 3'b000 && !wr_en));

  p_write_in_exec_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (op != 3'b000) |-> wr_en);

endmodule

bind seq_ctrl seq_ctrl_chk u_chk (
  .clk(clk), .rst_n(rst_n), .start(start), .dest(dest),
  .op(op), .wr_en(wr_en), .out_stb(out_stb), .done(done)
);

// File: tb/test_seq_ctrl.sv
module test_seq_ctrl;
  logic       clk = 1'b0;
  logic       rst_n;
  logic       start;
  logic [2:0] instr;
  logic [1:0] dest;
  logic [2:0] op;
  logic       wr_en, out_stb, done;

  int checks = 0;
  int fails  = 0;
  bit run    = 1'b0;

  always #4 clk = ~clk;

  seq_ctrl i_seq_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .instr(instr), .dest(dest),
    .op(op), .wr_en(wr_en), .out_stb(out_stb), .done(done)
  );

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d t=%0t", tag, act, exp, $time);
    end
  endtask

  // reference model: queue of pending operations, 8 marks the output step
  int q[$];
  bit m_done  = 1'b0;
  bit m_armed = 1'b1;

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      q.delete();
      m_done  = 1'b0;
      m_armed = 1'b1;
    end else if (q.size() > 0) begin
      void'(q.pop_front());
      m_done = (q.size() == 0);
      if (!start) m_armed = 1'b1;
    end else begin
      m_done = 1'b0;
      if (start && !dest[1] && m_armed) begin
        m_armed = 1'b0;
        case (instr)
          3'd0: q.push_back(1);
          3'd1: q.push_back(2);
          3'd2: q.push_back(3);
          3'd3: q.push_back(4);
          3'd4: q.push_back(5);
          3'd5: begin q.push_back(6); q.push_back(5); end
          3'd6: q.push_back(7);
          default: q.push_back(8);
        endcase
      end else if (!start) m_armed = 1'b1;
    end
  end

  always @(negedge clk) begin
    if (run && rst_n) begin
      int e_op, e_wr, e_stb;
      if (q.size() == 0) begin e_op = 0; e_wr = 0; e_stb = 0; end
      else if (q[0] == 8) begin e_op = 0; e_wr = 0; e_stb = 1; end
      else begin e_op = q[0]; e_wr = 1; e_stb = 0; end
      chk(int'(op) == e_op, "R3 op", int'(op), e_op);
      chk(int'(wr_en) == e_wr, "R7 wr_en", int'(wr_en), e_wr);
      chk(int'(out_stb) == e_stb, "R8 out_stb", int'(out_stb), e_stb);
      chk(done == m_done, "R6 done", int'(done), int'(m_done));
    end
  end

  task automatic issue(input logic [2:0] i, input logic [1:0] d);
    @(negedge clk);
    start = 1'b1; instr = i; dest = d;
    @(negedge clk);
    start = 1'b0;
  endtask

  task automatic idle(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    #(8 * 200000);
    fails++; checks++;
    $display("FAIL watchdog expired");
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

  initial begin
    int writes;
    rst_n = 1'b0; start = 1'b0; instr = 3'd0; dest = 2'b00;
    idle(2);
    chk(op == 3'b000 && !wr_en && !out_stb && !done, "R1 reset idle", int'(op), 0);
    rst_n = 1'b1;
    run = 1'b1;

    // R2: dest[1] high blocks decode while start is held
    @(negedge clk);
    start = 1'b1; instr = 3'd4; dest = 2'b10;
    for (int k = 0; k < 5; k++) begin
      @(negedge clk);
      chk(op == 3'b000 && !wr_en, "R2 blocked", int'(wr_en), 0);
    end
    start = 1'b0; dest = 2'b00;
    idle(2);

    // R10 + R4: load with dest[0] set
    issue(3'd0, 2'b01);
    chk(op == 3'b001 && wr_en, "R10 load dest0", int'(op), 1);
    @(negedge clk);
    chk(op == 3'b000 && done, "R4 back to decode", int'(done), 1);
    @(negedge clk);
    chk(!done, "R6 done one cycle", int'(done), 0);

    // R5: subtract sequence
    issue(3'd5, 2'b00);
    chk(op == 3'b110 && wr_en && !done, "R5 negate", int'(op), 6);
    @(negedge clk);
    chk(op == 3'b101 && !done, "R5 add after negate", int'(op), 5);
    @(negedge clk);
    chk(op == 3'b000 && done, "R5 end", int'(done), 1);
    idle(2);

    // R3: every instruction code
    for (int i = 0; i < 8; i++) begin
      issue(3'(i), 2'b00);
      idle(4);
    end

    // R8: output state
    issue(3'd7, 2'b00);
    chk(out_stb && op == 3'b000 && !wr_en, "R8 output", int'(out_stb), 1);
    idle(3);

    // R9: held start yields one execution
    @(negedge clk);
    start = 1'b1; instr = 3'd4; dest = 2'b00;
    writes = 0;
    for (int k = 0; k < 8; k++) begin
      @(negedge clk);
      if (wr_en) writes++;
    end
    chk(writes == 1, "R9 held start", writes, 1);
    start = 1'b0;
    @(negedge clk);
    start = 1'b1;
    @(negedge clk);
    start = 1'b0;
    chk(op == 3'b101, "R9 re-armed", int'(op), 5);
    idle(3);

    // R9: low start during execute re-arms, new instr taken in done cycle
    issue(3'd5, 2'b00);
    @(negedge clk);
    start = 1'b1; instr = 3'd2;
    @(negedge clk);
    chk(done, "R9 done cycle", int'(done), 1);
    @(negedge clk);
    start = 1'b0;
    chk(op == 3'b011, "R9 taken at done", int'(op), 3);
    idle(3);

    // R1: reset mid-subtract
    issue(3'd5, 2'b00);
    rst_n = 1'b0;
    #1;
    chk(op == 3'b000 && !wr_en && !done, "R1 async reset", int'(op), 0);
    @(negedge clk);
    rst_n = 1'b1;
    idle(3);
    chk(op == 3'b000 && !done, "R1 stays idle", int'(op), 0);

    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end
endmodule